// File: doc/BRIEF.md
# Bridge Drive Gating with Speed PWM and Fault Latch

This block sits between the commutation logic of a brushless DC motor controller and the six switches of its three-phase bridge. It takes six commutation requests, three for the high-side switches and three for the low-side switches. It then applies four kinds of gating before registering the final drive bits:

- a static brake,
- a drive enable,
- a latched overcurrent fault,
- a speed PWM.

The PWM acts on the low-side switches only. The high-side switches switch only at the commutation rate.

Speed is set by a digital trip value. A free-running ramp counter stands in for an analog sawtooth. The low sides conduct only while the trip value is below the ramp.

An overcurrent level input sets a fault latch, and the latch blocks every drive. The latch re-arms on one of two events: a rising edge of the enable, or the wrap of the ramp. In either case the overcurrent level must already be gone when the event occurs. This limits how fast the drive can retry into a fault.

Top module: `bldc_drive_gate`

## Requirements
- R1: While reset is high, all six drive bits and the fault status are 0 at the next clock edge. Reset also sets the ramp counter to 0.
- R2: When brake is high, the drive becomes high sides 0 and low sides 1 (drive = 6'b111000 for three phases). This holds regardless of enable, overcurrent, the fault latch, the trip value or the requests.
- R3: With brake low and enable low, all six drive bits are 0.
- R4: With brake low, a high overcurrent level turns all drive bits off at the next edge. The same edge sets the fault status to 1.
- R5: A rising edge of enable, while the overcurrent level is low, clears the fault status at that edge. Drives resume one clock later.
- R6: The ramp counter is RAMP_W bits wide (8 by default). It counts up by one per clock and wraps from its maximum to 0. The edge at which the ramp holds its maximum clears the fault status if the overcurrent level is low.
- R7: If the overcurrent level is high when a re-arm event (enable rise or ramp wrap) occurs, the fault status stays 1.
- R8: A low-side drive bit is 1 only if its request is 1 and the ramp value at that edge is strictly greater than the trip value. A trip of 0 therefore drives at every count except 0. A trip at the maximum never drives.
- R9: In normal running, the high-side drive bits equal their requests at every ramp value. Normal running means brake low, enable high, no overcurrent and no fault.
- R10: Every drive bit is registered: a change at any input appears on the drive one clock after the edge that samples it.
- R11: Request and drive bit order is [2:0] = high sides of phases A..C and [5:3] = low sides of phases A..C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_req | input | 2*PHASES | Commutation requests, high sides in low bits |
| brake | input | 1 | Static brake, highest priority |
| enable | input | 1 | Drive enable; its rising edge re-arms the fault |
| oc_level | input | 1 | Overcurrent level, active high |
| trip | input | RAMP_W | Speed trip value compared against the ramp |
| drive | output | 2*PHASES | Registered bridge drive bits |
| fault_latched | output | 1 | Overcurrent fault latch status |

## Verification
The hardest situations to reach from the ports are the re-arm events that coincide with a still-present fault, or that come from the ramp wrap rather than from enable. The ramp has no output, so the bench keeps its own count of clocks since reset release. It holds enable high and waits for the count to reach the maximum. It then checks the fault status after that edge, once with the overcurrent level held high and once with it low. The same count lets the bench predict the PWM level of each low-side bit.

// File: rtl/bldc_gate_pkg.sv
package bldc_gate_pkg;
  typedef enum logic [1:0] {
    GATE_OFF   = 2'd0,
    GATE_RUN   = 2'd1,
    GATE_BRAKE = 2'd2
  } gate_mode_e;
endpackage

// File: rtl/gate_ramp.sv
module gate_ramp #(
  parameter int RAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RAMP_W-1:0] trip,
  output logic              wrap,
  output logic              pwm_on
);
  localparam logic [RAMP_W-1:0] RAMP_MAX = '1;

  logic [RAMP_W-1:0] ramp_q;

  always_ff @(posedge clk) begin
    if (rst) ramp_q <= '0;
    else     ramp_q <= ramp_q + 1'b1;
  end

  assign wrap   = (ramp_q == RAMP_MAX);
  assign pwm_on = (ramp_q > trip);
endmodule

// File: rtl/gate_fault_latch.sv
module gate_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic oc_level,
  input  logic enable,
  input  logic wrap,
  output logic latched
);
  logic en_q;
  logic rearm;

  always_ff @(posedge clk) en_q <= enable;

  assign rearm = wrap | (enable & ~en_q);

  always_ff @(posedge clk) begin
    if (rst)           latched <= 1'b0;
    else if (oc_level) latched <= 1'b1;
    else if (rearm)    latched <= 1'b0;
  end
endmodule

// File: rtl/gate_drive_stage.sv
module gate_drive_stage
  import bldc_gate_pkg::*;
#(
  parameter int PHASES = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  gate_mode_e            mode,
  input  logic                  pwm_on,
  input  logic [2*PHASES-1:0]   req,
  output logic [2*PHASES-1:0]   drv
);
  localparam int NB = 2 * PHASES;

  logic [NB-1:0] drv_d;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    always_comb begin
      unique case (mode)
        GATE_BRAKE: begin
          drv_d[p]          = 1'b0;
          drv_d[PHASES + p] = 1'b1;
        end
        GATE_RUN: begin
          drv_d[p]          = req[p];
          drv_d[PHASES + p] = req[PHASES + p] & pwm_on;
        end
        default: begin
          drv_d[p]          = 1'b0;
          drv_d[PHASES + p] = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drv <= '0;
    else     drv <= drv_d;
  end
endmodule

// File: rtl/bldc_drive_gate.sv
module bldc_drive_gate
  import bldc_gate_pkg::*;
#(
  parameter int PHASES = 3,
  parameter int RAMP_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*PHASES-1:0] cmd_req,
  input  logic                brake,
  input  logic                enable,
  input  logic                oc_level,
  input  logic [RAMP_W-1:0]   trip,
  output logic [2*PHASES-1:0] drive,
  output logic                fault_latched
);
  logic       wrap;
  logic       pwm_on;
  gate_mode_e mode;

  gate_ramp #(.RAMP_W(RAMP_W)) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .trip   (trip),
    .wrap   (wrap),
    .pwm_on (pwm_on)
  );

  gate_fault_latch u_fault (
    .clk      (clk),
    .rst      (rst),
    .oc_level (oc_level),
    .enable   (enable),
    .wrap     (wrap),
    .latched  (fault_latched)
  );

  always_comb begin
    if (brake)                                      mode = GATE_BRAKE;
    else if (!enable || oc_level || fault_latched)  mode = GATE_OFF;
    else                                            mode = GATE_RUN;
  end

  gate_drive_stage #(.PHASES(PHASES)) u_stage (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .pwm_on (pwm_on),
    .req    (cmd_req),
    .drv    (drive)
  );
endmodule

// File: rtl/bldc_drive_gate_chk.sv
module bldc_drive_gate_chk #(
  parameter int PHASES = 3,
  parameter int RAMP_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [2*PHASES-1:0] cmd_req,
  input logic                brake,
  input logic                enable,
  input logic                oc_level,
  input logic [RAMP_W-1:0]   trip,
  input logic [2*PHASES-1:0] drive,
  input logic                fault_latched
);
  localparam logic [2*PHASES-1:0] BRAKE_PAT = {{PHASES{1'b1}}, {PHASES{1'b0}}};

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (drive == '0) && !fault_latched);

  assert_brake_pattern_R2: assert property (@(posedge clk) disable iff (rst)
    brake |=> drive == BRAKE_PAT);

  assert_enable_off_R3: assert property (@(posedge clk) disable iff (rst)
    !brake && !enable |=> drive == '0);

  assert_oc_trip_R4: assert property (@(posedge clk) disable iff (rst)
    !brake && oc_level |=> (drive == '0) && fault_latched);

  assert_enable_rearm_R5: assert property (@(posedge clk) disable iff (rst)
    fault_latched && !oc_level && enable && !$past(enable) |=> !fault_latched);

  assert_hold_fault_R7: assert property (@(posedge clk) disable iff (rst)
    oc_level |=> fault_latched);

  assert_lowside_subset_R8: assert property (@(posedge clk) disable iff (rst)
    !brake |=> (drive[2*PHASES-1:PHASES] & ~$past(cmd_req[2*PHASES-1:PHASES])) == '0);

  assert_highside_follow_R9: assert property (@(posedge clk) disable iff (rst)
    !brake && enable && !oc_level && !fault_latched
      |=> drive[PHASES-1:0] == $past(cmd_req[PHASES-1:0]));

  assert_trip_max_R8: assert property (@(posedge clk) disable iff (rst)
    !brake && (trip == '1) |=> drive[2*PHASES-1:PHASES] == '0);
endmodule

bind bldc_drive_gate bldc_drive_gate_chk #(.PHASES(PHASES), .RAMP_W(RAMP_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_req       (cmd_req),
  .brake         (brake),
  .enable        (enable),
  .oc_level      (oc_level),
  .trip          (trip),
  .drive         (drive),
  .fault_latched (fault_latched)
);

// File: tb/bldc_drive_gate_test.sv
module bldc_drive_gate_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cmd_req = '0;
  logic       brake = 1'b0;
  logic       enable = 1'b0;
  logic       oc_level = 1'b0;
  logic [7:0] trip = '0;
  logic [5:0] drive;
  logic       fault_latched;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] ramp_m = '0;

  always #10 clk = ~clk;

  always @(posedge clk) ramp_m <= rst ? 8'd0 : ramp_m + 8'd1;

  bldc_drive_gate uut (
    .clk(clk), .rst(rst), .cmd_req(cmd_req), .brake(brake), .enable(enable),
    .oc_level(oc_level), .trip(trip), .drive(drive), .fault_latched(fault_latched)
  );

  // {brake, enable, trip, req, expected drive before low-side PWM}
  localparam int NV = 8;
  localparam logic [21:0] VECS [NV] = '{
    {1'b0, 1'b1, 8'd0,   6'b010001, 6'b010001},
    {1'b0, 1'b1, 8'd0,   6'b001100, 6'b001100},
    {1'b1, 1'b1, 8'd0,   6'b010001, 6'b111000},
    {1'b0, 1'b0, 8'd0,   6'b001100, 6'b000000},
    {1'b1, 1'b0, 8'd77,  6'b100010, 6'b111000},
    {1'b0, 1'b1, 8'd255, 6'b100010, 6'b100010},
    {1'b0, 1'b1, 8'd128, 6'b100001, 6'b100001},
    {1'b0, 1'b1, 8'd0,   6'b111111, 6'b111111}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] pwm_mask(input logic [5:0] full, input logic [7:0] r,
                                          input logic [7:0] t);
    return (r > t) ? full : {3'b000, full[2:0]};
  endfunction

  task automatic wait_ramp(input logic [7:0] v);
    while (ramp_m != v) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rp;
    // R1: reset wins over brake
    brake = 1'b1; cmd_req = 6'b111111;
    repeat (3) @(negedge clk);
    check("R1 drive in reset", {2'b0, drive}, 8'h00);
    check("R1 fault in reset", {7'b0, fault_latched}, 8'h00);
    brake = 1'b0; enable = 1'b1; cmd_req = '0;
    @(negedge clk);
    rst = 1'b0;
    // R8: first post-reset edge uses ramp 0, so trip 0 gives no low side
    cmd_req = 6'b001001; trip = 8'd0;
    @(negedge clk);
    check("R8 ramp starts at 0", {2'b0, drive}, 8'h01);
    @(negedge clk);
    check("R8 ramp 1 above trip 0", {2'b0, drive}, 8'h09);

    // table walk: R2 R3 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      brake = VECS[i][21]; enable = VECS[i][20]; trip = VECS[i][19:12];
      cmd_req = VECS[i][11:6];
      rp = ramp_m;
      @(negedge clk);
      if (VECS[i][21] || !VECS[i][20])
        check($sformatf("R2/R3 vec %0d", i), {2'b0, drive}, {2'b0, VECS[i][5:0]});
      else
        check($sformatf("R8/R9 vec %0d", i), {2'b0, drive},
              {2'b0, pwm_mask(VECS[i][5:0], rp, VECS[i][19:12])});
    end

    // R8 duty sweep over a full ramp
    brake = 1'b0; enable = 1'b1; trip = 8'd100; cmd_req = 6'b110010;
    for (int k = 0; k < 260; k++) begin
      rp = ramp_m;
      @(negedge clk);
      check("R8 sweep", {2'b0, drive}, {2'b0, pwm_mask(6'b110010, rp, 8'd100)});
    end

    // R10: brake release appears only after an edge
    brake = 1'b1;
    @(negedge clk);
    brake = 1'b0; enable = 1'b0;
    #3;
    check("R10 hold before edge", {2'b0, drive}, 8'h38);
    @(negedge clk);
    check("R10 change after edge", {2'b0, drive}, 8'h00);

    // R4: fault trip and hold
    enable = 1'b1; trip = 8'd0; cmd_req = 6'b001100;
    wait_ramp(8'd10);
    oc_level = 1'b1;
    @(negedge clk);
    check("R4 drive off", {2'b0, drive}, 8'h00);
    check("R4 fault set", {7'b0, fault_latched}, 8'h01);
    oc_level = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 fault held", {7'b0, fault_latched}, 8'h01);
    check("R4 drive held off", {2'b0, drive}, 8'h00);

    // R7: enable rise while fault present
    enable = 1'b0; @(negedge clk);
    enable = 1'b1; oc_level = 1'b1; @(negedge clk);
    check("R7 enable rise blocked", {7'b0, fault_latched}, 8'h01);
    oc_level = 1'b0; @(negedge clk);

    // R5: enable rise with fault gone
    enable = 1'b0; @(negedge clk);
    enable = 1'b1; @(negedge clk);
    check("R5 fault cleared", {7'b0, fault_latched}, 8'h00);
    check("R5 drive still off", {2'b0, drive}, 8'h00);
    @(negedge clk);
    check("R5 drive resumes", {2'b0, drive}, 8'h0C);

    // R7 then R6: ramp wrap re-arm
    wait_ramp(8'd40);
    oc_level = 1'b1;
    wait_ramp(8'd255);
    @(negedge clk);
    check("R7 wrap blocked by fault", {7'b0, fault_latched}, 8'h01);
    oc_level = 1'b0;
    wait_ramp(8'd200);
    check("R6 no clear mid ramp", {7'b0, fault_latched}, 8'h01);
    wait_ramp(8'd255);
    @(negedge clk);
    check("R6 wrap clears fault", {7'b0, fault_latched}, 8'h00);

    // R2: brake overrides a live fault
    oc_level = 1'b1; brake = 1'b1;
    @(negedge clk);
    check("R2 brake over fault", {2'b0, drive}, 8'h38);
    brake = 1'b0; oc_level = 1'b0;
    @(negedge clk);
    check("R4 off after brake", {2'b0, drive}, 8'h00);

    // R1: reset clears latch
    rst = 1'b1; @(negedge clk);
    check("R1 fault cleared by reset", {7'b0, fault_latched}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule